// File: doc/BRIEF.md
# Dual-Clock Port Queue with Selectable Fill Warning

This block is the per-port data queue that sits between a memory mover, clocked by the subsystem clock, and a network wrapper, clocked by an unrelated network clock. The memory mover pushes words on the write side. The network wrapper pops them on the read side. The queue smooths out delay jitter between the two, so that neither the memory nor the network has to be woken for a single word.

Each side gets a handshake flag. The write side sees `wnfull` and the read side sees `rnempty`. Pointers cross between the domains in Gray code through two-flop synchronizers. A warning output, `warn`, is produced in the write (subsystem) clock domain, where the port scheduler lives. The scheduler uses it to decide whether to activate the port. A 3-bit select picks the fill threshold for the warning from five levels. The warning is computed from the local write pointer and the synchronized read pointer, so it can lag a recent read by the synchronizer delay. In that case it errs toward reporting more fill than the queue really holds.

The depth is a power of two set by `AW`, and the word width is set by `DW`. The defaults are 16 words of 32 bits.

Top module: `dcq_warn`

## Requirements
- R1: After reset the queue is empty. `rnempty` is 0, `wnfull` is 1, and `warn` is 1 only for select code 4.
- R2: Words accepted by the queue (a write with `wen`=1 while `wnfull`=1) are presented on `rdata` in write order. `rdata` shows the oldest word while `rnempty`=1, and a read with `ren`=1 advances to the next word.
- R3: A write while `wnfull`=0 is ignored. The stored contents and the write pointer are unchanged, and the rejected word never appears on `rdata`.
- R4: A read while `rnempty`=0 is ignored. A later write followed by a read returns exactly that written word.
- R5: Once all pointers are synchronized, `wnfull` is 0 exactly when 2^AW words are held. The held count never exceeds 2^AW, and `wnfull` can only fall after an accepted write.
- R6: Once all pointers are synchronized, `rnempty` is 1 exactly when at least one word is held. `rnempty` can only fall after a read.
- R7: With `lvl_sel` at 1, 2 or 3, `warn` is 1 when the write-side count is at least one quarter, one half or three quarters of the depth, respectively.
- R8: With `lvl_sel`=0 or any of 5 to 7, `warn` means the count is not zero. With `lvl_sel`=4, `warn` means not full, equal to `wnfull`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Subsystem (write and warning) clock |
| wrst_n | input | 1 | Active-low asynchronous reset, write domain |
| wen | input | 1 | Write enable |
| wdata | input | DW | Write data |
| wnfull | output | 1 | Queue can accept a word |
| lvl_sel | input | 3 | Warning level select, codes 0..7 |
| warn | output | 1 | Fill warning for the scheduler |
| rclk | input | 1 | Network (read) clock |
| rrst_n | input | 1 | Active-low asynchronous reset, read domain |
| ren | input | 1 | Read enable |
| rdata | output | DW | Oldest held word, valid while rnempty |
| rnempty | output | 1 | Queue holds at least one word |

## Verification
The two kinds of result are due at different times, and the bench samples each one where it is due.

- **Same-domain results.** `wnfull`, `warn` and `rdata` follow the side's own registered pointer with no delay after its clock edge. The bench samples them at the falling edge before the next rising edge of that clock. Because `warn` is combinational in `lvl_sel`, it is checked a short delay after the select changes.
- **Cross-domain results.** The effect of a write on `rnempty`, and of a read on `wnfull` and `warn`, needs two edges of the other clock to cross the synchronizers, plus up to one more edge for phase. The exact flag and warning checks are therefore made only after four edges of each clock with no traffic.
- **During traffic.** The handshake is checked cycle by cycle from the flags sampled before each edge. Every popped word is compared with the bench's model queue.

// File: rtl/dcq_warn.sv
module dcq_warn #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  output logic          wnfull,
  input  logic [2:0]    lvl_sel,
  output logic          warn,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          ren,
  output logic [DW-1:0] rdata,
  output logic          rnempty
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULLC = (AW+1)'(DEPTH);
  localparam logic [AW:0] QTR   = (AW+1)'(DEPTH / 4);
  localparam logic [AW:0] HALF  = (AW+1)'(DEPTH / 2);
  localparam logic [AW:0] TQTR  = (AW+1)'((3 * DEPTH) / 4);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0] wbin, wgray, rbin, rgray;
  logic [AW:0] rg1, rg2, wg1, wg2;

  // write domain
  wire [AW:0] wbin_nx = wbin + 1'b1;
  wire [AW:0] wcount  = wbin - g2b(rg2);
  wire        wacc    = wen & wnfull;
  assign wnfull = (wcount != FULLC);

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wacc) begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end

  always_ff @(posedge wclk)
    if (wacc) mem[wbin[AW-1:0]] <= wdata;

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      rg1 <= '0;
      rg2 <= '0;
    end else begin
      rg1 <= rgray;
      rg2 <= rg1;
    end

  always_comb
    case (lvl_sel)
      3'd1:    warn = (wcount >= QTR);
      3'd2:    warn = (wcount >= HALF);
      3'd3:    warn = (wcount >= TQTR);
      3'd4:    warn = (wcount != FULLC);
      default: warn = (wcount != '0);
    endcase

  // read domain
  wire [AW:0] rbin_nx = rbin + 1'b1;
  wire        racc    = ren & rnempty;
  assign rnempty = (rbin != g2b(wg2));
  assign rdata   = mem[rbin[AW-1:0]];

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (racc) begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
    end

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      wg1 <= '0;
      wg2 <= '0;
    end else begin
      wg1 <= wgray;
      wg2 <= wg1;
    end
endmodule

// File: rtl/dcq_warn_chk.sv
module dcq_warn_chk #(
  parameter int AW = 4
) (
  input logic        wclk,
  input logic        wrst_n,
  input logic        wen,
  input logic        wnfull,
  input logic [2:0]  lvl_sel,
  input logic        warn,
  input logic [AW:0] wbin,
  input logic [AW:0] wcount,
  input logic        rclk,
  input logic        rrst_n,
  input logic        ren,
  input logic        rnempty,
  input logic [AW:0] rbin
);
  localparam logic [AW:0] FULLC = (AW+1)'(1 << AW);

  AST_WR_STEP: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wen && wnfull) |=> (wbin == (AW+1)'($past(wbin) + 1'b1))); // R2
  AST_WR_HELD_FULL: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wen && !wnfull) |=> (wbin == $past(wbin))); // R3
  AST_RD_HELD_EMPTY: assert property (@(posedge rclk) disable iff (!rrst_n)
    (ren && !rnempty) |=> (rbin == $past(rbin))); // R4
  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
    wcount <= FULLC); // R5
  AST_FULL_ONLY_BY_WRITE: assert property (@(posedge wclk) disable iff (!wrst_n)
    !wen |=> !$fell(wnfull)); // R5
  AST_EMPTY_ONLY_BY_READ: assert property (@(posedge rclk) disable iff (!rrst_n)
    !ren |=> !$fell(rnempty)); // R6
  AST_WARN_NOT_FULL: assert property (@(posedge wclk) disable iff (!wrst_n)
    (lvl_sel == 3'd4) |-> (warn == wnfull)); // R8
endmodule

bind dcq_warn dcq_warn_chk #(.AW(AW)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .wen(wen), .wnfull(wnfull),
  .lvl_sel(lvl_sel), .warn(warn), .wbin(wbin), .wcount(wcount),
  .rclk(rclk), .rrst_n(rrst_n), .ren(ren), .rnempty(rnempty), .rbin(rbin)
);

// File: tb/dcq_warn_tb.sv
`timescale 1ns/1ps
module dcq_warn_tb;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  logic wen = 0, ren = 0;
  logic [DW-1:0] wdata = '0;
  logic [2:0] lvl_sel = 3'd0;
  logic wnfull, warn, rnempty;
  logic [DW-1:0] rdata;

  always #2 wclk = ~wclk;
  always #3 rclk = ~rclk;

  dcq_warn #(.DW(DW), .AW(AW)) u_dut (
    .wclk(wclk), .wrst_n(wrst_n), .wen(wen), .wdata(wdata), .wnfull(wnfull),
    .lvl_sel(lvl_sel), .warn(warn), .rclk(rclk), .rrst_n(rrst_n), .ren(ren),
    .rdata(rdata), .rnempty(rnempty));

  int checks = 0, errors = 0;
  logic [DW-1:0] q[$];
  logic last_acc, last_have;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_warn(input int lvl, input int cnt);
    case (lvl)
      1: return cnt >= DEPTH / 4;
      2: return cnt >= DEPTH / 2;
      3: return cnt >= (3 * DEPTH) / 4;
      4: return cnt != DEPTH;
      default: return cnt != 0;
    endcase
  endfunction

  task automatic do_wr(input logic [DW-1:0] d);
    @(negedge wclk);
    wen = 1; wdata = d; last_acc = wnfull;
    @(posedge wclk); #0.5;
    wen = 0;
    if (last_acc) q.push_back(d);
  endtask

  task automatic do_rd();
    logic [DW-1:0] got;
    @(negedge rclk);
    ren = 1; last_have = rnempty; got = rdata;
    @(posedge rclk); #0.5;
    ren = 0;
    if (last_have) begin
      if (q.size() == 0) chk(0, "R4 read accepted with model empty", 1, 0);
      else begin
        chk(got == q[0], "R2 read order", got, q[0]);
        void'(q.pop_front());
      end
    end
  endtask

  task automatic settle_check();
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    @(negedge wclk);
    chk(wnfull == (q.size() != DEPTH), "R5 wnfull", wnfull, q.size() != DEPTH);
    for (int l = 0; l < 8; l++) begin
      lvl_sel = 3'(l); #0.2;
      if (l >= 1 && l <= 3) chk(warn == exp_warn(l, q.size()), "R7 warn level", warn, exp_warn(l, q.size()));
      else chk(warn == exp_warn(l, q.size()), "R8 warn level", warn, exp_warn(l, q.size()));
    end
    lvl_sel = 3'd0;
    @(negedge rclk);
    chk(rnempty == (q.size() != 0), "R6 rnempty", rnempty, q.size() != 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c1d));
    repeat (3) @(posedge wclk);
    wrst_n = 1; rrst_n = 1;
    // R1 reset state
    @(negedge wclk);
    chk(wnfull == 1, "R1 wnfull after reset", wnfull, 1);
    for (int l = 0; l < 8; l++) begin
      lvl_sel = 3'(l); #0.2;
      chk(warn == (l == 4), "R1 warn after reset", warn, l == 4);
    end
    lvl_sel = 0;
    @(negedge rclk);
    chk(rnempty == 0, "R1 rnempty after reset", rnempty, 0);

    // R4 read on empty ignored
    do_rd();
    chk(last_have == 0, "R4 read on empty accepted", last_have, 0);
    do_wr(32'hA5A5_0001);
    settle_check();
    do_rd();
    chk(last_have == 1, "R4 written word readable", last_have, 1);
    settle_check();

    // fill to full, with threshold checks on the way
    for (int i = 0; i < DEPTH; i++) begin
      do_wr(32'h1000_0000 + i);
      if (i % 4 == 3) settle_check();
    end
    chk(q.size() == DEPTH, "R5 all words accepted", q.size(), DEPTH);
    // R3 write while full ignored
    do_wr(32'hDEAD_BEEF);
    chk(last_acc == 0, "R3 write while full accepted", last_acc, 0);
    settle_check();
    for (int i = 0; i < DEPTH; i++) do_rd();
    settle_check();
    do_rd();
    chk(last_have == 0, "R3 rejected word appeared", last_have, 0);

    // constrained random traffic
    for (int blk = 0; blk < 40; blk++) begin
      int bias = $urandom_range(10, 90);
      for (int n = 0; n < 30; n++) begin
        if ($urandom_range(0, 99) < bias) do_wr($urandom());
        else do_rd();
      end
      settle_check();
    end
    while (q.size() != 0) do_rd();
    settle_check();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule